// File: doc/BRIEF.md
# Periodic reload timer channel

This block is one channel of a multi-channel timer peripheral. It occupies a 32-byte window on a plain 32-bit memory-mapped register bus. A control word picks a tick source, the reload and immediate-load behaviour, and the interrupt enable. Software can write that word directly. It can also use three alias addresses that set, clear or invert only the bits written as one, so no read-modify-write is needed.

A 16-bit fixed count holds the reload value and a 16-bit down-counter runs from it. The counter steps once per tick of the selected source. Each expiry sets an interrupt status bit. The interrupt output is a level and stays high while the status and enable bits are both set. Software acknowledges the interrupt by writing the status bit through the clear alias. To get an expiry rate `f` from a tick rate `T`, software programs `T/f - 1`.

The bus has no back-pressure. A write completes in the cycle in which `bus_sel` and `bus_we` are high. Read data is combinational from `bus_addr`. Clock generation is outside this block: each tick source arrives as a one-cycle enable strobe on `tick_src`.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word (offset 0x00) and the count register (offset 0x10) read zero, and `irq_o` is low.
- R2: A write to offset 0x00 replaces the writable control fields under the byte enables: source select [3:0], reload bit 6, immediate-load bit 7 and interrupt enable bit 14. All other control bits read zero. Reads of 0x00, 0x04, 0x08 and 0x0C return the control word.
- R3: A write to 0x04 ORs the written bits into control. A write to 0x08 clears them. A write to 0x0C inverts them. Bits outside the byte enables are untouched.
- R4: Status bit 15 is never set by a software write to 0x00, 0x04 or 0x0C. Only an expiry sets it.
- R5: Bits [15:0] of offset 0x10 are the fixed count. They are writable per byte, so a halfword write (byte enables 0011) is accepted. Bits [31:16] read the live counter, and writes to them are ignored.
- R6: A select value s in 1..15 takes `tick_src[s]` as the tick, where s = 8 is the 32 kHz strobe. A select of 0 stops the counter, whatever `tick_src[0]` does.
- R7: On a tick the counter decrements when it is non-zero. A tick at zero is an expiry. With reload set, an expiry reloads the fixed count, so expiries come every fixed count plus one ticks.
- R8: With reload clear, an expiry leaves the counter at zero and halts it. No further expiry occurs until the counter is loaded by an immediate-load write.
- R9: With bit 7 set, a write to the fixed count loads the counter in the same clock edge and releases a halt. With bit 7 clear, the counter is unchanged and the new value is used at the next reload.
- R10: `irq_o` equals status AND enable. Writing a one to bit 15 through 0x08 clears the status.
- R11: When an expiry and a status clear fall in the same cycle, the status stays set. An immediate load in the same cycle as a tick takes precedence and causes no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Channel window selected |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_src | input | 16 | Tick enable strobes, index = select value |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the channel with the default 16-bit count and 4-bit select, so all sixteen strobe inputs are present. This lets the bench drive unselected sources alongside the 32 kHz input at index 8. Small fixed counts such as 2 and 5 bring many reload periods and coincident expiry and acknowledge cycles into a few hundred clocks. The halfword and single-byte writes exercise the per-byte enables on both registers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W    = 4;
  localparam int NUM_SRC  = 2 ** SEL_W;
  localparam int B_RELOAD = 6;
  localparam int B_UPDATE = 7;
  localparam int B_IEN    = 14;
  localparam int B_IRQ    = 15;
  localparam logic [4:0] OFS_CNT = 5'h10;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'd0,
    WR_SET    = 2'd1,
    WR_CLR    = 2'd2,
    WR_TOG    = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic             irq;
    logic             ien;
    logic             update;
    logic             reload;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  wr_kind_e    kind_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] bmask_i,
  input  logic        expire_i,
  output ctrl_t       ctrl_o,
  output logic [31:0] word_o
);
  ctrl_t       ctrl_q;
  logic [31:0] cur, w, nxt;
  logic        irq_n;

  always_comb begin
    cur = '0;
    cur[SEL_W-1:0] = ctrl_q.sel;
    cur[B_RELOAD]  = ctrl_q.reload;
    cur[B_UPDATE]  = ctrl_q.update;
    cur[B_IEN]     = ctrl_q.ien;
    cur[B_IRQ]     = ctrl_q.irq;
  end

  always_comb begin
    w   = wdata_i & bmask_i;
    nxt = cur;
    if (we_i) begin
      unique case (kind_i)
        WR_DIRECT: nxt = (cur & ~bmask_i) | w;
        WR_SET:    nxt = cur | w;
        WR_CLR:    nxt = cur & ~w;
        WR_TOG:    nxt = cur ^ w;
      endcase
    end
    // status: software may only clear it, hardware expiry wins
    irq_n = (we_i && kind_i == WR_CLR) ? nxt[B_IRQ] : cur[B_IRQ];
    if (expire_i) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q.sel    <= nxt[SEL_W-1:0];
      ctrl_q.reload <= nxt[B_RELOAD];
      ctrl_q.update <= nxt[B_UPDATE];
      ctrl_q.ien    <= nxt[B_IEN];
      ctrl_q.irq    <= irq_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign word_o = cur;

  p_irq_hw_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.irq) |-> $past(expire_i));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && kind_i == WR_CLR && bmask_i[B_IRQ] && wdata_i[B_IRQ] && !expire_i)
    |=> !ctrl_q.irq);

  p_expiry_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> ctrl_q.irq);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               reload_i,
  input  logic               update_i,
  input  logic [CNT_W/8-1:0] fix_be_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   fixed_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               expire_o
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] fixed_q, fixed_nxt, count_q;
  logic             halted_q, tick, load_now;

  for (genvar b = 0; b < NB; b++) begin : g_fix_byte
    assign fixed_nxt[b*8 +: 8] = fix_be_i[b] ? wdata_i[b*8 +: 8] : fixed_q[b*8 +: 8];
  end

  assign tick     = (sel_i != '0) && tick_src[sel_i];
  assign load_now = update_i && (|fix_be_i);
  assign expire_o = tick && !halted_q && (count_q == '0) && !load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fixed_q  <= '0;
      count_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      fixed_q <= fixed_nxt;
      if (load_now) begin
        count_q  <= fixed_nxt;
        halted_q <= 1'b0;
      end else if (expire_o) begin
        count_q  <= reload_i ? fixed_q : '0;
        halted_q <= !reload_i;
      end else if (tick && count_q != '0) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign fixed_o = fixed_q;
  assign count_o = count_q;

  p_sel_zero_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0 && !load_now) |=> $stable(count_q));

  p_decrement_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q != '0 && !load_now) |=> (count_q == $past(count_q) - 1'b1));

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !load_now) |=> (count_q == '0));

  p_immediate_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (count_q == $past(fixed_nxt)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [4:0]         bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] tick_src,
  output logic               irq_o
);
  localparam int NB = CNT_W / 8;

  logic             wr, ctrl_wr, cnt_wr, expire;
  logic [31:0]      bmask, ctrl_word;
  logic [NB-1:0]    fix_be;
  logic [CNT_W-1:0] fixed, count;
  ctrl_t            ctrl;
  wr_kind_e         kind;

  for (genvar b = 0; b < 4; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{bus_be[b]}};
  end

  assign wr      = bus_sel && bus_we;
  assign ctrl_wr = wr && !bus_addr[4] && (bus_addr[1:0] == 2'b00);
  assign cnt_wr  = wr && (bus_addr == OFS_CNT);
  assign kind    = wr_kind_e'(bus_addr[3:2]);
  assign fix_be  = cnt_wr ? bus_be[NB-1:0] : '0;

  tmr_ctrl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (ctrl_wr),
    .kind_i   (kind),
    .wdata_i  (bus_wdata),
    .bmask_i  (bmask),
    .expire_i (expire),
    .ctrl_o   (ctrl),
    .word_o   (ctrl_word)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_src (tick_src),
    .sel_i    (ctrl.sel),
    .reload_i (ctrl.reload),
    .update_i (ctrl.update),
    .fix_be_i (fix_be),
    .wdata_i  (bus_wdata[CNT_W-1:0]),
    .fixed_o  (fixed),
    .count_o  (count),
    .expire_o (expire)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[4] && bus_addr[1:0] == 2'b00) begin
      bus_rdata = ctrl_word;
    end else if (bus_addr == OFS_CNT) begin
      bus_rdata[15:0]  = 16'(fixed);
      bus_rdata[31:16] = 16'(count);
    end
  end

  assign irq_o = ctrl.irq && ctrl.ien;

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && kind == WR_DIRECT && bus_be[1] && !bus_wdata[B_IEN]) |=> !irq_o);
endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_b = 1'b0, we_b = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] tk = '0;
  logic        irq;

  int    vectors = 0, fails = 0;
  string req = "R1";

  always #10 clk = ~clk;

  tmr_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_we(we_b),
    .bus_addr(addr), .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata),
    .tick_src(tk), .irq_o(irq)
  );

  // behavioural reference
  logic [3:0]  m_sel;
  logic        m_rel, m_upd, m_ien, m_irq, m_halt;
  logic [15:0] m_fix, m_cnt;

  function automatic logic [31:0] m_ctrl();
    return {16'd0, m_irq, m_ien, 6'd0, m_upd, m_rel, 2'd0, m_sel};
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a == 5'h00 || a == 5'h04 || a == 5'h08 || a == 5'h0C) return m_ctrl();
    if (a == 5'h10) return {m_cnt, m_fix};
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_rel = 0; m_upd = 0; m_ien = 0; m_irq = 0;
      m_halt = 0; m_fix = 0; m_cnt = 0;
    end else begin
      logic [31:0] bm, w, c, n;
      logic [15:0] nf;
      logic        wr, tick, load, ex, irq_n;
      bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      w  = wdata & bm;
      c  = m_ctrl();
      wr = sel_b && we_b;
      tick = (m_sel != 0) && tk[m_sel];
      nf = m_fix;
      if (wr && addr == 5'h10) begin
        if (be[0]) nf[7:0]  = wdata[7:0];
        if (be[1]) nf[15:8] = wdata[15:8];
      end
      load = wr && addr == 5'h10 && m_upd && (be[0] || be[1]);
      ex = 0;
      if (load) begin
        m_cnt = nf; m_halt = 0;
      end else if (tick && !m_halt) begin
        if (m_cnt == 0) begin
          ex = 1;
          if (m_rel) m_cnt = m_fix;
          else m_halt = 1;
        end else m_cnt = m_cnt - 1;
      end
      n = c;
      if (wr && (addr == 5'h00)) n = (c & ~bm) | w;
      if (wr && (addr == 5'h04)) n = c | w;
      if (wr && (addr == 5'h08)) n = c & ~w;
      if (wr && (addr == 5'h0C)) n = c ^ w;
      irq_n = (wr && addr == 5'h08) ? n[15] : c[15];
      if (ex) irq_n = 1;
      m_sel = n[3:0]; m_rel = n[6]; m_upd = n[7]; m_ien = n[14]; m_irq = irq_n;
      m_fix = nf;
    end
  end

  task automatic check();
    logic [31:0] er;
    logic        ei;
    er = m_read(addr);
    ei = m_irq && m_ien;
    vectors++;
    if (rdata !== er || irq !== ei) begin
      fails++;
      $display("FAIL %s: addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
               req, addr, rdata, irq, er, ei);
    end
  endtask

  // check outputs of previous cycle, then drive this cycle
  task automatic step(input logic w, input logic [4:0] a, input logic [3:0] b,
                      input logic [31:0] d, input logic [15:0] t);
    @(negedge clk);
    check();
    sel_b = w; we_b = w; addr = a; be = b; wdata = d; tk = t;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] t);
    step(1'b0, a, 4'h0, 32'h0, t);
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] b, input logic [31:0] d);
    step(1'b1, a, b, d, 16'h0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h00, 0); rd(5'h10, 0); rd(5'h04, 0); rd(5'h14, 0);

    // R2 direct write, partial byte enables
    req = "R2";
    wr(5'h00, 4'hF, 32'hFFFF_FFFF); rd(5'h00, 0); rd(5'h0C, 0);
    wr(5'h00, 4'h1, 32'h0000_0000); rd(5'h00, 0);
    wr(5'h00, 4'hF, 32'h0000_0000); rd(5'h08, 0);

    // R3 aliases
    req = "R3";
    wr(5'h04, 4'hF, 32'h0000_4005); rd(5'h00, 0);
    wr(5'h04, 4'hF, 32'h0000_0042); rd(5'h00, 0);
    wr(5'h08, 4'hF, 32'h0000_0041); rd(5'h00, 0);
    wr(5'h0C, 4'hF, 32'h0000_40C3); rd(5'h00, 0);
    wr(5'h0C, 4'h2, 32'h0000_FFFF); rd(5'h00, 0);

    // R4 software cannot set status
    req = "R4";
    wr(5'h00, 4'hF, 32'h0000_C000); rd(5'h00, 0);
    wr(5'h04, 4'hF, 32'h0000_8000); rd(5'h00, 0);
    wr(5'h0C, 4'hF, 32'h0000_8000); rd(5'h00, 0);
    wr(5'h00, 4'hF, 32'h0);

    // R5 count register byte access, upper half read-only
    req = "R5";
    wr(5'h10, 4'hF, 32'hABCD_1234); rd(5'h10, 0);
    wr(5'h10, 4'h3, 32'h5555_0007); rd(5'h10, 0);
    wr(5'h10, 4'h2, 32'h0000_0100); rd(5'h10, 0);

    // R9 immediate load vs deferred
    req = "R9";
    wr(5'h04, 4'hF, 32'h0000_0080);
    wr(5'h10, 4'h3, 32'h0000_0005); rd(5'h10, 0);
    wr(5'h08, 4'hF, 32'h0000_0080);
    wr(5'h10, 4'h3, 32'h0000_0002); rd(5'h10, 0);

    // R6/R7 32 kHz source with reload, other strobes active too
    req = "R7";
    wr(5'h00, 4'hF, 32'h0000_4048);
    for (int i = 0; i < 60; i++) rd(5'h10, (i % 3 == 0) ? 16'h0108 : 16'h0006);
    req = "R10";
    wr(5'h08, 4'hF, 32'h0000_8000); rd(5'h00, 0); rd(5'h10, 0);
    for (int i = 0; i < 20; i++) rd(5'h00, 16'h0100);
    wr(5'h08, 4'hF, 32'h0000_4000); rd(5'h00, 16'h0100);
    wr(5'h04, 4'hF, 32'h0000_4000); rd(5'h00, 0);

    // R11 acknowledge racing expiry; tick every cycle, fixed 2
    req = "R11";
    for (int i = 0; i < 12; i++) step(1'b1, 5'h08, 4'hF, 32'h0000_8000, 16'h0100);
    // immediate load racing a tick
    wr(5'h04, 4'hF, 32'h0000_0080);
    step(1'b1, 5'h10, 4'h3, 32'h0000_0000, 16'h0100);
    step(1'b1, 5'h10, 4'h3, 32'h0000_0003, 16'h0100);
    for (int i = 0; i < 6; i++) rd(5'h10, 16'h0100);

    // R6 select zero stops counter
    req = "R6";
    wr(5'h10, 4'h3, 32'h0000_0009);
    wr(5'h08, 4'hF, 32'h0000_000F);
    for (int i = 0; i < 10; i++) rd(5'h10, 16'hFFFF);
    wr(5'h04, 4'hF, 32'h0000_0003);
    for (int i = 0; i < 10; i++) rd(5'h10, (i % 2 == 0) ? 16'h0008 : 16'h0100);

    // R8 one-shot halt, then rearm via immediate load
    req = "R8";
    wr(5'h08, 4'hF, 32'h0000_80CF);
    wr(5'h04, 4'hF, 32'h0000_4008);
    for (int i = 0; i < 15; i++) rd(5'h10, 16'h0100);
    wr(5'h08, 4'hF, 32'h0000_8000);
    for (int i = 0; i < 8; i++) rd(5'h00, 16'h0100);
    wr(5'h04, 4'hF, 32'h0000_0080);
    wr(5'h10, 4'h3, 32'h0000_0001);
    for (int i = 0; i < 6; i++) rd(5'h10, 16'h0100);
    rd(5'h00, 0);

    @(negedge clk);
    check();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule